// File: doc/BRIEF.md
# Queued SPI Word Sequencer

This block feeds an existing 24-bit serial write engine from a small on-chip queue. Upstream logic pushes 24-bit configuration words into a 16-entry synchronous FIFO at any time. The sequencer drains the queue on its own and passes the words to the engine one at a time.

Each word goes through a fixed handshake. The word is popped and placed on the parallel data bus. A one-cycle capture strobe follows. On the next cycle the engine's enable rises and stays high until the engine reports completion. The enable then drops, and a programmable idle interval runs before the next word may start.

The engine keeps its chip select low only while its enable is high. The enforced low interval on the enable therefore gives a chip-select-high gap between consecutive serial transfers. The serial shifting itself, which sends the MSB first at half the system clock, belongs to the engine and is outside this block.

Top module: `spi_word_feeder`

## Requirements
- R1: Reset is synchronous and active low. After reset, `fifo_empty`=1, `fifo_full`=0, `overflow`=0, `busy`=0, `drv_enable`=0 and `drv_latch`=0.
- R2: Every accepted word appears unchanged on `drv_data` (bit 23 is the MSB) while `drv_latch` is high. Words leave in the order they were pushed.
- R3: `drv_latch` is high for exactly one clock cycle per word.
- R4: `drv_enable` rises in the clock cycle directly after the `drv_latch` cycle. The two are never high in the same cycle.
- R5: Once `drv_enable` is high, it stays high until `drv_done` is sampled high on a rising edge. It is low from that edge on.
- R6: When a further word is already queued, exactly GAP_CYCLES+2 cycles (default 6) pass between the fall of `drv_enable` and the next `drv_latch`. In those cycles both `drv_enable` and `drv_latch` are low.
- R7: With the FIFO empty the sequencer stays idle: no strobe, no enable, `busy` low.
- R8: The FIFO holds DEPTH (16) words, and `fifo_full` is high when it holds 16. A push while `fifo_full` is high is dropped and sets `overflow`. `overflow` stays set until reset.
- R9: `busy` is high from the pop of a word through the end of its idle interval. It is always high while `drv_enable` is high, and it is low once the queue has drained.
- R10: A push in the same cycle as a pop is accepted, and FIFO order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Write a word into the queue this cycle |
| push_word | input | 24 | Word to queue |
| fifo_full | output | 1 | Queue holds DEPTH words |
| fifo_empty | output | 1 | Queue holds no words |
| overflow | output | 1 | Sticky: a push was dropped while full |
| drv_data | output | 24 | Word offered to the serial engine |
| drv_latch | output | 1 | One-cycle capture strobe for `drv_data` |
| drv_enable | output | 1 | Start/hold enable to the serial engine |
| drv_done | input | 1 | Completion pulse from the serial engine |
| busy | output | 1 | A word is in flight or its idle interval is running |

## Verification
A push and a pop can land in the same cycle. This happens when upstream writes into the queue on the edge where the sequencer takes the head word. The bench provokes it by pushing three words on consecutive cycles into an empty, idle queue, so that the third push coincides with the pop of the first. It judges the case by the order and the count of words that reach the engine, and by the flags afterwards. Overflow is provoked by stalling the modelled engine's completion so that the queue fills behind a word that is still in flight.

// File: rtl/spi_word_feeder.sv
module spi_word_feeder #(
  parameter int WORD_W     = 24,
  parameter int DEPTH      = 16,
  parameter int GAP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [WORD_W-1:0] push_word,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              overflow,
  output logic [WORD_W-1:0] drv_data,
  output logic              drv_latch,
  output logic              drv_enable,
  input  logic              drv_done,
  output logic              busy
);
  localparam int PW = $clog2(DEPTH);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_POP, S_LATCH, S_ENABLE, S_WAIT, S_GAP} state_t;

  state_t            state;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW:0]       wr_ptr, rd_ptr;
  logic [GW-1:0]     gap_cnt;

  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);

  wire do_push = push_valid && !fifo_full;
  wire do_pop  = (state == S_POP);

  assign drv_latch  = (state == S_LATCH);
  assign drv_enable = (state == S_ENABLE) || (state == S_WAIT);
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr[PW-1:0]] <= push_word;

  always_ff @(posedge clk)
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
      drv_data <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (push_valid && fifo_full) overflow <= 1'b1;
      if (do_pop) begin
        drv_data <= mem[rd_ptr[PW-1:0]];
        rd_ptr   <= rd_ptr + 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      state   <= S_IDLE;
      gap_cnt <= '0;
    end else begin
      case (state)
        S_IDLE:   if (!fifo_empty) state <= S_POP;
        S_POP:    state <= S_LATCH;
        S_LATCH:  state <= S_ENABLE;
        S_ENABLE, S_WAIT: begin
          if (drv_done) begin
            state   <= S_GAP;
            gap_cnt <= '0;
          end else begin
            state <= S_WAIT;
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_LAST) state <= S_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
endmodule

module spi_word_feeder_chk (
  input logic clk,
  input logic rst_n,
  input logic push_valid,
  input logic fifo_full,
  input logic fifo_empty,
  input logic overflow,
  input logic drv_latch,
  input logic drv_enable,
  input logic drv_done,
  input logic busy
);
  a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    drv_latch |=> !drv_latch);
  a_r4_enable_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
    drv_latch |=> drv_enable);
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_latch && drv_enable));
  a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_enable && !drv_done) |=> drv_enable);
  a_r5_enable_release: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_enable && drv_done) |=> !drv_enable);
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(push_valid && fifo_full));
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
  a_r9_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_enable || drv_latch) |-> busy);
endmodule

bind spi_word_feeder spi_word_feeder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .overflow(overflow), .drv_latch(drv_latch),
  .drv_enable(drv_enable), .drv_done(drv_done), .busy(busy)
);

// File: tb/tb_spi_word_feeder.sv
`timescale 1ns / 1ps
module tb_spi_word_feeder;
  localparam int CLK_PERIOD = 50;
  localparam int GAP        = 4;
  localparam int DONE_LAT   = 49;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [23:0] push_word = '0;
  logic        fifo_full, fifo_empty, overflow;
  logic [23:0] drv_data;
  logic        drv_latch, drv_enable, busy;
  logic        drv_done = 1'b0;

  int checks = 0;
  int fails = 0;

  logic [23:0] got[$];
  int          gaps[$];
  int          seq_err = 0;
  int          n_latch = 0;
  bit          stall = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_feeder #(.WORD_W(24), .DEPTH(16), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow),
    .drv_data(drv_data), .drv_latch(drv_latch), .drv_enable(drv_enable),
    .drv_done(drv_done), .busy(busy)
  );

  // Monitor and serial-engine model, both evaluated mid-cycle.
  bit prev_en = 1'b0, expect_en = 1'b0, expect_rel = 1'b0, counting = 1'b0;
  int gap_cnt = 0, en_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (expect_en) begin
        if (!drv_enable || drv_latch) seq_err++;
        expect_en = 1'b0;
      end
      if (drv_latch) begin
        got.push_back(drv_data);
        n_latch++;
        expect_en = 1'b1;
        if (counting) gaps.push_back(gap_cnt);
        counting = 1'b0;
      end
      if (expect_rel) begin
        if (drv_enable) seq_err++;
        expect_rel = 1'b0;
      end
      if (drv_enable && drv_done) expect_rel = 1'b1;
      if (prev_en && !drv_enable) begin
        counting = 1'b1;
        gap_cnt = 0;
      end
      if (counting && !drv_enable && !drv_latch) gap_cnt++;
      if ((drv_enable || drv_latch) && !busy) seq_err++;
      prev_en = drv_enable;
    end
    drv_done = 1'b0;
    if (!drv_enable) en_cnt = 0;
    else if (!stall) begin
      en_cnt++;
      if (en_cnt == DONE_LAT) drv_done = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push_burst(input logic [23:0] w[$]);
    foreach (w[i]) begin
      push_valid = 1'b1;
      push_word  = w[i];
      @(negedge clk);
    end
    push_valid = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (fifo_empty && !busy && !drv_enable) break;
    end
  endtask

  task automatic check_order(input string req, input logic [23:0] exp[$]);
    chk(got.size() == exp.size(), req, "word count", 64'(got.size()), 64'(exp.size()));
    foreach (exp[i])
      if (i < got.size()) chk(got[i] == exp[i], req, $sformatf("word %0d", i), 64'(got[i]), 64'(exp[i]));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    push_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(fifo_empty === 1'b1, "R1", "empty in reset", 64'(fifo_empty), 1);
    chk(fifo_full === 1'b0 && overflow === 1'b0, "R1", "full/overflow in reset", 64'({fifo_full, overflow}), 0);
    chk(busy === 1'b0 && drv_enable === 1'b0 && drv_latch === 1'b0, "R1", "busy/enable/latch in reset",
        64'({busy, drv_enable, drv_latch}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_latch == 0 && !busy && !drv_enable, "R7", "idle with empty queue", 64'(n_latch), 0);
  endtask

  task automatic t_two_words;
    logic [23:0] w[$];
    w = '{24'hA5A5A5, 24'hCDCDCD};
    got.delete(); gaps.delete(); seq_err = 0;
    push_burst(w);
    wait_idle();
    check_order("R2", w);
    chk(gaps.size() == 1 && gaps[0] == GAP + 2, "R6", "idle interval between words",
        64'(gaps.size() > 0 ? gaps[0] : -1), 64'(GAP + 2));
    chk(seq_err == 0, "R4", "latch then enable sequence (R3/R5 also)", 64'(seq_err), 0);
    chk(!busy, "R9", "busy low after drain", 64'(busy), 0);
  endtask

  task automatic t_push_during_pop;
    logic [23:0] w[$];
    w = '{24'h123456, 24'h800001, 24'h00FF00};
    got.delete(); seq_err = 0;
    push_burst(w);
    chk(!fifo_empty, "R10", "two words left after same-cycle push/pop", 64'(fifo_empty), 0);
    wait_idle();
    check_order("R10", w);
    chk(seq_err == 0, "R5", "enable hold/release", 64'(seq_err), 0);
  endtask

  task automatic t_overflow;
    logic [23:0] first[$];
    logic [23:0] fill[$];
    logic [23:0] exp[$];
    got.delete(); seq_err = 0;
    stall = 1'b1;
    first = '{24'hF00001};
    push_burst(first);
    for (int i = 0; i < 200 && !drv_enable; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(drv_enable && busy, "R9", "busy while word held by engine", 64'({drv_enable, busy}), 3);
    for (int i = 0; i < 16; i++) fill.push_back(24'h100000 + 24'(i * 24'h010203));
    push_burst(fill);
    chk(fifo_full && !overflow, "R8", "full after 16 words", 64'({fifo_full, overflow}), 2);
    first = '{24'hDEAD00};
    push_burst(first);
    chk(overflow && fifo_full, "R8", "overflow on push while full", 64'({fifo_full, overflow}), 3);
    chk(drv_enable, "R5", "enable held without done", 64'(drv_enable), 1);
    stall = 1'b0;
    wait_idle();
    exp = '{24'hF00001};
    foreach (fill[i]) exp.push_back(fill[i]);
    check_order("R8", exp);
    chk(overflow, "R8", "overflow sticky after drain", 64'(overflow), 1);
    chk(seq_err == 0, "R3", "strobe and enable sequence", 64'(seq_err), 0);
    do_reset();
    chk(!overflow && fifo_empty, "R1", "reset clears overflow", 64'({overflow, fifo_empty}), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_two_words();
    t_push_during_pop();
    t_overflow();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule